// File: doc/BRIEF.md
# Engine Channel Command Controller

This block is the control and status logic for one channel of a descriptor-driven data-movement engine. Software programs it through a small register port. Four registers are visible: a configuration register, an operation-mode register, a next-descriptor pointer and an activation register. The activation register takes start, stop, pause and restart commands. It reports a two-bit channel status and a sticky error flag.

The channel is always idle, active or paused. Each command is accepted only in the states where it is legal. A start command also checks that the descriptor pointer is aligned as the current operation mode requires. When a launch is accepted, the block sends a one-cycle start pulse to the datapath. A stop sends a one-cycle abort pulse. The datapath reports the end of a chain on a done input, which returns the channel to idle.

Top module: `xcc_chan_ctrl`

Register addresses:

| Address | Register |
|---|---|
| 0 | configuration |
| 1 | descriptor pointer |
| 2 | activation |
| 3 | mode |

Reads are combinational and follow `reg_addr`. Writes take effect at the clock edge where `reg_wr` is high.

## Requirements
- R1: After reset, the configuration register reads 0x444: access-protect bit 2 set, source burst [7:4]=4, destination burst [11:8]=4, and mode [1:0]=0 (XOR). The pointer and activation registers read 0. The outputs `dp_start`, `dp_abort`, `dp_run` and `err_flag` are low.
- R2: A configuration write (address 0) stores bits [11:2] only. Bits [1:0] keep the operation mode, and bits [31:12] read as 0.
- R3: Writes to the mode register (address 3, bits [1:0]) and to the pointer register (address 1) take effect only while the status is idle. The mode encodings are 0 XOR, 1 CRC32, 2 DMA copy and 3 memory-init. The mode reads back in configuration bits [1:0] and on `dp_mode`.
- R4: The activation register sits at address 2. The command bits are start=bit 0, stop=bit 1, pause=bit 2 and restart=bit 3. Status is in [5:4], encoded 0 idle, 1 active, 2 paused. The error flag is bit 8. A legal start from idle moves the status to active in the cycle after the write, pulses `dp_start` for that one cycle, and raises `dp_run`.
- R5: A start is refused if the pointer is misaligned for the mode. XOR needs pointer bits [5:0] clear. DMA and CRC32 need bits [4:0] clear. Memory-init has no constraint. A refused start leaves the status unchanged, gives no `dp_start`, and sets the error flag.
- R6: Pause moves active to paused and drops `dp_run`. Restart moves paused to active without a `dp_start` pulse.
- R7: Start while paused is legal. It re-checks alignment, moves the status to active, and pulses `dp_start`.
- R8: Stop while active forces idle in the next cycle and pulses `dp_abort` once. Stop while idle is a no-op and sets no error.
- R9: Any other command/state pair is ignored and sets the error flag. These pairs are start while active, pause while idle or paused, restart while idle or active, and stop while paused.
- R10: The error flag is sticky. Writing 1 to bit 8 clears it, and writing 0 leaves it set.
- R11: `dp_done` while active returns the status to idle. `dp_done` while idle or paused has no effect.
- R12: Command bits read back as 0. When several command bits are written together, only the highest-priority one acts: stop, then pause, then restart, then start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dp_done | input | 1 | Datapath finished the chain |
| dp_start | output | 1 | One-cycle launch pulse to the datapath |
| dp_abort | output | 1 | One-cycle abort pulse to the datapath |
| dp_run | output | 1 | High while the status is active |
| dp_mode | output | 2 | Current operation mode |
| dp_desc_ptr | output | 32 | Current descriptor pointer |
| err_flag | output | 1 | Sticky command/alignment error |

## Verification
The hardest situation to reach is a start while paused. It needs a pointer and mode that were fixed before the first launch, because both registers are locked once the channel leaves idle. The stimulus therefore loads an aligned DMA pointer, launches, and pauses. It then issues start and compares the resulting pulse with the one from a restart. It also drives a spurious done while paused, and attempts mode and pointer writes while active, to show these locked states cannot be disturbed.

// File: rtl/xcc_pkg.sv
// Package xcc_pkg
// Shared encodings for the channel command controller: status values,
// operation modes, register addresses and activation-register bit positions.
// Assumes a 2-bit register address space with four registers.
package xcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PAUSED = 2'd2
    } chan_st_e;

    typedef enum logic [1:0] {
        MD_XOR  = 2'd0,
        MD_CRC  = 2'd1,
        MD_DMA  = 2'd2,
        MD_FILL = 2'd3
    } op_mode_e;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_PTR  = 2'd1;
    localparam logic [1:0] A_ACT  = 2'd2;
    localparam logic [1:0] A_MODE = 2'd3;

    localparam int B_START   = 0;
    localparam int B_STOP    = 1;
    localparam int B_PAUSE   = 2;
    localparam int B_RESTART = 3;
    localparam int B_ST_LO   = 4;
    localparam int B_ERR     = 8;

endpackage

// File: rtl/xcc_cfg_regs.sv
// Module xcc_cfg_regs
// Holds the general configuration bits, the operation-mode field and the
// descriptor pointer. General configuration writes never touch the mode.
// Mode and pointer writes are accepted only while the channel is idle.
// Assumes write strobes are already decoded by the caller.
module xcc_cfg_regs
    import xcc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CFG_LO  = 2,
    parameter int CFG_HI  = 11,
    parameter logic [CFG_HI:CFG_LO] CFG_RST = 10'h111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               mode_we,
    input  logic               ptr_we,
    input  logic [DATA_W-1:0]  wdata,
    input  chan_st_e           status,
    output logic [CFG_HI:CFG_LO] cfg_bits,
    output op_mode_e           mode,
    output logic [DATA_W-1:0]  ptr
);

    logic chan_idle;
    assign chan_idle = (status == ST_IDLE);

    // General configuration bits; the mode field lives in a separate register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_bits <= CFG_RST;
        else if (cfg_we) cfg_bits <= wdata[CFG_HI:CFG_LO];
    end

    // Operation mode, locked while a chain is active or paused.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mode <= MD_XOR;
        else if (mode_we && chan_idle)   mode <= op_mode_e'(wdata[1:0]);
    end

    // Next-descriptor pointer, locked while a chain is active or paused.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ptr <= '0;
        else if (ptr_we && chan_idle)  ptr <= wdata;
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status != ST_IDLE) |=> $stable(mode)); // R3
    AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status != ST_IDLE) |=> $stable(ptr)); // R3

endmodule

// File: rtl/xcc_align_chk.sv
// Module xcc_align_chk
// Combinational alignment check of the descriptor pointer against the
// current operation mode. XOR chains need a coarser alignment than copy
// and CRC chains; memory-init has no pointer constraint.
module xcc_align_chk
    import xcc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int XOR_ALIGN = 6,
    parameter int STD_ALIGN = 5
) (
    input  op_mode_e          mode,
    input  logic [DATA_W-1:0] ptr,
    output logic              ptr_ok
);

    localparam int MAX_ALIGN = (XOR_ALIGN > STD_ALIGN) ? XOR_ALIGN : STD_ALIGN;

    logic [MAX_ALIGN-1:0] low_bits;
    logic                 xor_clear;
    logic                 std_clear;

    assign low_bits  = ptr[MAX_ALIGN-1:0];
    assign xor_clear = (low_bits[XOR_ALIGN-1:0] == '0);
    assign std_clear = (low_bits[STD_ALIGN-1:0] == '0);

    // Select the alignment rule that applies to the current mode.
    always_comb begin
        unique case (mode)
            MD_XOR:          ptr_ok = xor_clear;
            MD_CRC, MD_DMA:  ptr_ok = std_clear;
            default:         ptr_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/xcc_chan_fsm.sv
// Module xcc_chan_fsm
// Three-state channel machine (idle, active, paused) with per-command
// legality rules and a sticky error flag cleared by write-one.
// Assumes at most one activation write per cycle; a done from the
// datapath while active takes precedence over a same-cycle command.
module xcc_chan_fsm
    import xcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_we,
    input  logic     cmd_start,
    input  logic     cmd_stop,
    input  logic     cmd_pause,
    input  logic     cmd_restart,
    input  logic     err_clr,
    input  logic     ptr_ok,
    input  logic     dp_done,
    output chan_st_e status,
    output logic     err,
    output logic     dp_start,
    output logic     dp_abort
);

    chan_st_e st_n;
    logic     go_n;
    logic     abort_n;
    logic     bad_n;
    logic     done_hit;

    assign done_hit = dp_done && (status == ST_ACTIVE);

    // Next-state decode with command priority stop > pause > restart > start.
    always_comb begin
        st_n    = status;
        go_n    = 1'b0;
        abort_n = 1'b0;
        bad_n   = 1'b0;
        if (done_hit) begin
            st_n = ST_IDLE;
        end else if (cmd_we) begin
            if (cmd_stop) begin
                if (status == ST_ACTIVE) begin
                    st_n    = ST_IDLE;
                    abort_n = 1'b1;
                end else if (status != ST_IDLE) begin
                    bad_n = 1'b1;
                end
            end else if (cmd_pause) begin
                if (status == ST_ACTIVE) st_n = ST_PAUSED;
                else                     bad_n = 1'b1;
            end else if (cmd_restart) begin
                if (status == ST_PAUSED) st_n = ST_ACTIVE;
                else                     bad_n = 1'b1;
            end else if (cmd_start) begin
                if (status == ST_ACTIVE) begin
                    bad_n = 1'b1;
                end else if (ptr_ok) begin
                    st_n = ST_ACTIVE;
                    go_n = 1'b1;
                end else begin
                    bad_n = 1'b1;
                end
            end
        end
    end

    // State and one-cycle datapath pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status   <= ST_IDLE;
            dp_start <= 1'b0;
            dp_abort <= 1'b0;
        end else begin
            status   <= st_n;
            dp_start <= go_n;
            dp_abort <= abort_n;
        end
    end

    // Sticky error flag: a new error wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)  err <= 1'b0;
        else         err <= bad_n | (err & ~(cmd_we & err_clr));
    end

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3); // R4
    AST_START_ENTERS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> (status == ST_ACTIVE && $past(status) != ST_ACTIVE)); // R7
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_abort |-> (status == ST_IDLE && $past(status) == ST_ACTIVE)); // R8
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_start && dp_abort)); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cmd_we && err_clr)) |=> err); // R10
    AST_PAUSED_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) == ST_PAUSED && status == ST_ACTIVE && !dp_start)
            |-> $past(cmd_we && cmd_restart)); // R6

endmodule

// File: rtl/xcc_chan_ctrl.sv
// Module xcc_chan_ctrl (top)
// Per-channel command controller: address decode, register read mux and
// wiring of the configuration registers, alignment check and channel FSM.
// Assumes a single-cycle write strobe and combinational reads.
module xcc_chan_ctrl
    import xcc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int XOR_ALIGN = 6,
    parameter int STD_ALIGN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dp_done,
    output logic              dp_start,
    output logic              dp_abort,
    output logic              dp_run,
    output logic [1:0]        dp_mode,
    output logic [DATA_W-1:0] dp_desc_ptr,
    output logic              err_flag
);

    localparam int CFG_LO = 2;
    localparam int CFG_HI = 11;

    logic [CFG_HI:CFG_LO] cfg_bits;
    op_mode_e             mode;
    logic [DATA_W-1:0]    ptr;
    chan_st_e             status;
    logic                 err;
    logic                 ptr_ok;
    logic                 cfg_we, mode_we, ptr_we, act_we;

    // Write-strobe decode per register.
    assign cfg_we  = reg_wr && (reg_addr == A_CFG);
    assign ptr_we  = reg_wr && (reg_addr == A_PTR);
    assign act_we  = reg_wr && (reg_addr == A_ACT);
    assign mode_we = reg_wr && (reg_addr == A_MODE);

    xcc_cfg_regs #(
        .DATA_W (DATA_W),
        .CFG_LO (CFG_LO),
        .CFG_HI (CFG_HI),
        .CFG_RST(10'h111)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .mode_we (mode_we),
        .ptr_we  (ptr_we),
        .wdata   (reg_wdata),
        .status  (status),
        .cfg_bits(cfg_bits),
        .mode    (mode),
        .ptr     (ptr)
    );

    xcc_align_chk #(
        .DATA_W   (DATA_W),
        .XOR_ALIGN(XOR_ALIGN),
        .STD_ALIGN(STD_ALIGN)
    ) u_align (
        .mode  (mode),
        .ptr   (ptr),
        .ptr_ok(ptr_ok)
    );

    xcc_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (act_we),
        .cmd_start  (reg_wdata[B_START]),
        .cmd_stop   (reg_wdata[B_STOP]),
        .cmd_pause  (reg_wdata[B_PAUSE]),
        .cmd_restart(reg_wdata[B_RESTART]),
        .err_clr    (reg_wdata[B_ERR]),
        .ptr_ok     (ptr_ok),
        .dp_done    (dp_done),
        .status     (status),
        .err        (err),
        .dp_start   (dp_start),
        .dp_abort   (dp_abort)
    );

    // Read mux; command bits are not stored and read as zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG: begin
                reg_rdata[CFG_HI:CFG_LO] = cfg_bits;
                reg_rdata[1:0]           = mode;
            end
            A_PTR:  reg_rdata = ptr;
            A_ACT: begin
                reg_rdata[B_ST_LO+1:B_ST_LO] = status;
                reg_rdata[B_ERR]             = err;
            end
            default: reg_rdata[1:0] = mode;
        endcase
    end

    assign dp_run      = (status == ST_ACTIVE);
    assign dp_mode     = mode;
    assign dp_desc_ptr = ptr;
    assign err_flag    = err;

    AST_RUN_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_run && !$past(dp_run)) |-> (dp_start || $past(act_we))); // R4
    AST_LAUNCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> $past(ptr_ok)); // R5

endmodule

// File: tb/test_xcc_chan_ctrl.sv
module test_xcc_chan_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam int S_RD    = 0;
    localparam int S_START = 1;
    localparam int S_ABORT = 2;
    localparam int S_RUN   = 3;
    localparam int S_ERR   = 4;
    localparam int S_MODE  = 5;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dp_done = 1'b0;
    logic        dp_start, dp_abort, dp_run, err_flag;
    logic [1:0]  dp_mode;
    logic [31:0] dp_desc_ptr;

    exp_t q[$];
    logic mon_req = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcc_chan_ctrl i_xcc_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_done(dp_done),
        .dp_start(dp_start), .dp_abort(dp_abort), .dp_run(dp_run),
        .dp_mode(dp_mode), .dp_desc_ptr(dp_desc_ptr), .err_flag(err_flag)
    );

    // Monitor: pops expected items and compares at the falling edge.
    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.sel)
                S_RD:    act = reg_rdata;
                S_START: act = {31'd0, dp_start};
                S_ABORT: act = {31'd0, dp_abort};
                S_RUN:   act = {31'd0, dp_run};
                S_ERR:   act = {31'd0, err_flag};
                default: act = {30'd0, dp_mode};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1;
        dp_done = 1'b1;
        @(posedge clk); #1;
        dp_done = 1'b0;
    endtask

    task automatic expect_v(input int sel, input logic [1:0] a,
                            input logic [31:0] e, input string tag);
        exp_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        reg_addr = a;
        q.push_back(it);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_v(S_RD, 2'd0, 32'h444, "R1 cfg reset");
        expect_v(S_RD, 2'd1, 32'h0,   "R1 ptr reset");
        expect_v(S_RD, 2'd2, 32'h0,   "R1 act reset");
        expect_v(S_RUN, 2'd0, 32'h0,  "R1 run low");
        expect_v(S_ERR, 2'd0, 32'h0,  "R1 err low");

        // R2 / R3 mode held across configuration writes
        wr(2'd3, 32'h2);
        expect_v(S_MODE, 2'd0, 32'h2,  "R3 dp_mode DMA");
        expect_v(S_RD, 2'd0, 32'h446,  "R3 cfg shows mode");
        wr(2'd0, 32'hFFFF_FFFF);
        expect_v(S_RD, 2'd0, 32'hFFE,  "R2 cfg write keeps mode");
        wr(2'd0, 32'h444);

        // R5 misaligned DMA start refused
        wr(2'd1, 32'h1010);
        wr(2'd2, 32'h1);
        expect_v(S_START, 2'd2, 32'h0,  "R5 no start misaligned DMA");
        expect_v(S_RD, 2'd2, 32'h100,   "R5 error set status idle");
        // R10 sticky, W1C
        wr(2'd2, 32'h0);
        expect_v(S_RD, 2'd2, 32'h100,   "R10 write 0 keeps error");
        wr(2'd2, 32'h100);
        expect_v(S_RD, 2'd2, 32'h0,     "R10 write 1 clears error");

        // R4 legal launch
        wr(2'd1, 32'h1020);
        wr(2'd2, 32'h1);
        expect_v(S_START, 2'd2, 32'h1,  "R4 start pulse");
        expect_v(S_START, 2'd2, 32'h0,  "R4 start pulse one cycle");
        expect_v(S_RD, 2'd2, 32'h010,   "R4 status active R12 cmd bits zero");
        expect_v(S_RUN, 2'd2, 32'h1,    "R4 run high");

        // R3 locked while active
        wr(2'd3, 32'h0);
        expect_v(S_RD, 2'd0, 32'h446,   "R3 mode locked while active");
        wr(2'd1, 32'h5000);
        expect_v(S_RD, 2'd1, 32'h1020,  "R3 ptr locked while active");

        // R9 start while active
        wr(2'd2, 32'h1);
        expect_v(S_RD, 2'd2, 32'h110,   "R9 start while active");
        wr(2'd2, 32'h100);

        // R6 pause
        wr(2'd2, 32'h4);
        expect_v(S_RD, 2'd2, 32'h020,   "R6 paused");
        expect_v(S_RUN, 2'd2, 32'h0,    "R6 run low when paused");
        // R11 done while paused ignored
        pulse_done();
        expect_v(S_RD, 2'd2, 32'h020,   "R11 done ignored while paused");
        // R9 pause while paused, stop while paused
        wr(2'd2, 32'h4);
        expect_v(S_RD, 2'd2, 32'h120,   "R9 pause while paused");
        wr(2'd2, 32'h100);
        wr(2'd2, 32'h2);
        expect_v(S_RD, 2'd2, 32'h120,   "R9 stop while paused");
        wr(2'd2, 32'h100);

        // R6 restart: active, no start pulse
        wr(2'd2, 32'h8);
        expect_v(S_START, 2'd2, 32'h0,  "R6 restart no start pulse");
        expect_v(S_RD, 2'd2, 32'h010,   "R6 restart to active");

        // R7 start from paused
        wr(2'd2, 32'h4);
        wr(2'd2, 32'h1);
        expect_v(S_START, 2'd2, 32'h1,  "R7 start from paused pulses");
        expect_v(S_RD, 2'd2, 32'h010,   "R7 active after start from paused");

        // R11 done while active
        pulse_done();
        expect_v(S_RD, 2'd2, 32'h000,   "R11 done returns idle");

        // R8 stop while idle is no-op
        wr(2'd2, 32'h2);
        expect_v(S_ABORT, 2'd2, 32'h0,  "R8 no abort from idle");
        expect_v(S_RD, 2'd2, 32'h000,   "R8 stop idle no error");
        // R8 stop while active
        wr(2'd2, 32'h1);
        wr(2'd2, 32'h2);
        expect_v(S_ABORT, 2'd2, 32'h1,  "R8 abort pulse");
        expect_v(S_RD, 2'd2, 32'h000,   "R8 idle after stop");

        // R5 XOR alignment
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h1);
        expect_v(S_RD, 2'd2, 32'h100,   "R5 XOR needs bit5 clear");
        wr(2'd2, 32'h100);
        wr(2'd1, 32'h1040);
        wr(2'd2, 32'h1);
        expect_v(S_RD, 2'd2, 32'h010,   "R5 XOR aligned launch");
        wr(2'd2, 32'h2);
        // R5 CRC accepts 32-byte alignment
        wr(2'd3, 32'h1);
        wr(2'd1, 32'h1020);
        wr(2'd2, 32'h1);
        expect_v(S_RD, 2'd2, 32'h010,   "R5 CRC aligned launch");
        wr(2'd2, 32'h2);
        // R5 memory-init: no constraint
        wr(2'd3, 32'h3);
        wr(2'd1, 32'h1003);
        wr(2'd2, 32'h1);
        expect_v(S_RD, 2'd2, 32'h010,   "R5 memory-init any pointer");

        // R12 priority: stop beats pause
        wr(2'd2, 32'h6);
        expect_v(S_ABORT, 2'd2, 32'h1,  "R12 stop wins over pause");
        expect_v(S_RD, 2'd2, 32'h000,   "R12 idle after combined write");
        // R12 stop beats start when idle: nothing happens
        wr(2'd2, 32'h3);
        expect_v(S_START, 2'd2, 32'h0,  "R12 stop masks start");
        expect_v(S_RD, 2'd2, 32'h000,   "R12 idle, no error");

        // R9 restart while idle
        wr(2'd2, 32'h8);
        expect_v(S_RD, 2'd2, 32'h100,   "R9 restart while idle");
        expect_v(S_ERR, 2'd2, 32'h1,    "R9 err_flag port");

        repeat (2) @(posedge clk);
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule